// File: doc/BRIEF.md
# Three-Counter Performance Monitor

This block counts activity inside a processor core. It holds one free-running cycle counter and two event counters. Each event counter picks one line out of a vector of single-cycle event pulses, using an 8-bit event code. One control word holds the whole setup: the global run bit, two self-clearing reset strobes, a cycle prescale choice, an interrupt enable for each counter, a sticky wrap flag for each counter, and the two event codes.

Software reaches the block through a small word-addressed register port. Offset 0 is the control word, offset 1 is the cycle counter, offset 2 is event counter 0 and offset 3 is event counter 1. Reads are combinational from the offset. A write takes effect at the next clock edge. A level interrupt stays high while any wrap flag is set and its enable is also set. A typical use is to preload a counter close to its top value, set the counter's interrupt enable, and service the interrupt when the counter wraps.

Top module: `perfmon_unit`

## Requirements
- R1: After reset the control word reads 0x0FFF_F000. Both event codes then hold 0xFF, and all other fields are 0. All three counters read 0 and `irq` is low.
- R2: Control bit positions are: run at bit 0, event reset strobe at bit 1, cycle reset strobe at bit 2, prescale at bit 3, interrupt enables at bits 6:4, wrap flags at bits 10:8, counter 0 code at bits 19:12 and counter 1 code at bits 27:20. Bits 2:1, 7, 11 and 31:28 always read 0.
- R3: While the run bit is 0, no counter advances.
- R4: While running, event counter k advances by exactly one on each clock edge where `evt_i[code_k]` is high. Both counters may advance on the same edge.
- R5: Event code 0xFF never advances a counter, even when `evt_i[255]` is high.
- R6: While running with prescale off, the cycle counter advances on every edge. With prescale on, it advances once every 2**PSC_LOG2 running edges (64 by default). The phase of that division restarts at the cycle reset strobe.
- R7: A control write with bit 1 set clears both event counters. A control write with bit 2 set clears the cycle counter and its prescale phase. A clear wins over counting on the same edge, and neither strobe bit is stored.
- R8: Writes to offsets 1, 2 and 3 load the addressed counter. A load wins over counting on the same edge, and the loaded value reads back.
- R9: A counter that advances from 0xFFFF_FFFF to 0 sets its wrap flag. The flags are bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R10: Writing 1 to a wrap flag clears it, and writing 0 leaves it as it is. If a wrap and a clear of the same flag fall on one edge, the flag ends up set.
- R11: `irq` is high exactly while some wrap flag is set together with its enable: bit 4 for event counter 0, bit 5 for event counter 1, bit 6 for the cycle counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| evt_i | input | 2**SEL_W | Event pulses, indexed by event code |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with 32-bit counters and PSC_LOG2 = 2. With that setting a prescaled cycle tick comes every four running clocks, so the prescale phase, and its restart at the cycle reset strobe, show up within a few cycles. Counter wraps are reached by preloading values just below 0xFFFF_FFFF through the register port. The schedule also lines a wrap up with a flag-clear write on the same edge, and lines a reset strobe up with an active event pulse on the same edge.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int CODE_W = 8;

    // Control word bit positions
    localparam int B_RUN     = 0;
    localparam int B_RST_EV  = 1;
    localparam int B_RST_CYC = 2;
    localparam int B_PSC     = 3;
    localparam int B_IE_LO   = 4;
    localparam int B_WF_LO   = 8;
    localparam int B_CODE0   = 12;
    localparam int B_CODE1   = 20;

    // Flag / enable index: 0 event counter 0, 1 event counter 1, 2 cycle counter
    localparam int N_SRC = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CTRL = 2'd0,
        OFS_CYC  = 2'd1,
        OFS_EV0  = 2'd2,
        OFS_EV1  = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic              run;
        logic              psc;
        logic [N_SRC-1:0]  ie;
        logic [N_SRC-1:0]  wf;
        logic [CODE_W-1:0] code0;
        logic [CODE_W-1:0] code1;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        run: 1'b0, psc: 1'b0, ie: '0, wf: '0,
        code0: '1, code1: '1
    };
endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt  = cnt_q;
    assign wrap = inc && !ld && !clr && (&cnt_q);
endmodule

// File: rtl/perfmon_prescaler.sv
module perfmon_prescaler #(
    parameter int LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam logic [LOG2-1:0] ONE = LOG2'(1);

    logic [LOG2-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + ONE;
        end
    end

    assign tick = run && (&phase_q);
endmodule

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
    import perfmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_SRC-1:0]  wrap,
    output ctrl_t             ctl,
    output logic              rst_ev,
    output logic              rst_cyc,
    output logic [DATA_W-1:0] image,
    output logic              irq
);
    ctrl_t ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTRL_RST;
        end else if (wr) begin
            ctl_q.run   <= wdata[B_RUN];
            ctl_q.psc   <= wdata[B_PSC];
            ctl_q.ie    <= wdata[B_IE_LO +: N_SRC];
            ctl_q.code0 <= wdata[B_CODE0 +: CODE_W];
            ctl_q.code1 <= wdata[B_CODE1 +: CODE_W];
            // a wrap on the clearing edge keeps its flag
            ctl_q.wf    <= (ctl_q.wf & ~wdata[B_WF_LO +: N_SRC]) | wrap;
        end else begin
            ctl_q.wf    <= ctl_q.wf | wrap;
        end
    end

    always_comb begin
        image                      = '0;
        image[B_RUN]               = ctl_q.run;
        image[B_PSC]               = ctl_q.psc;
        image[B_IE_LO +: N_SRC]    = ctl_q.ie;
        image[B_WF_LO +: N_SRC]    = ctl_q.wf;
        image[B_CODE0 +: CODE_W]   = ctl_q.code0;
        image[B_CODE1 +: CODE_W]   = ctl_q.code1;
    end

    assign ctl     = ctl_q;
    assign rst_ev  = wr && wdata[B_RST_EV];
    assign rst_cyc = wr && wdata[B_RST_CYC];
    assign irq     = |(ctl_q.wf & ctl_q.ie);
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int SEL_W    = CODE_W,
    parameter int PSC_LOG2 = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [(1<<SEL_W)-1:0] evt_i,
    output logic                  irq
);
    localparam int NUM_EVT = 1 << SEL_W;
    localparam int N_EV    = 2;

    ctrl_t              ctl_q;
    logic               rst_ev, rst_cyc;
    logic [DATA_W-1:0]  ctrl_img;
    logic [N_SRC-1:0]   wrap_v;
    logic               wr_ctrl, wr_cyc;
    logic [N_EV-1:0]    wr_ev;
    logic               psc_tick, cyc_inc;
    logic [CNT_W-1:0]   cyc_val;
    logic [CNT_W-1:0]   ev_val [N_EV];

    // register write decode
    always_comb begin
        wr_ctrl = 1'b0;
        wr_cyc  = 1'b0;
        wr_ev   = '0;
        if (wr_en) begin
            unique case (reg_ofs_e'(addr))
                OFS_CTRL: wr_ctrl  = 1'b1;
                OFS_CYC:  wr_cyc   = 1'b1;
                OFS_EV0:  wr_ev[0] = 1'b1;
                OFS_EV1:  wr_ev[1] = 1'b1;
            endcase
        end
    end

    perfmon_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_ctrl),
        .wdata   (wdata),
        .wrap    (wrap_v),
        .ctl     (ctl_q),
        .rst_ev  (rst_ev),
        .rst_cyc (rst_cyc),
        .image   (ctrl_img),
        .irq     (irq)
    );

    perfmon_prescaler #(.LOG2(PSC_LOG2)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rst_cyc),
        .run   (ctl_q.run),
        .tick  (psc_tick)
    );

    assign cyc_inc = ctl_q.run && (!ctl_q.psc || psc_tick);

    perfmon_counter #(.W(CNT_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (wr_cyc),
        .ld_val (wdata[CNT_W-1:0]),
        .clr    (rst_cyc),
        .inc    (cyc_inc),
        .cnt    (cyc_val),
        .wrap   (wrap_v[2])
    );

    for (genvar g = 0; g < N_EV; g++) begin : g_ev
        logic [SEL_W-1:0] code;
        logic             hit;

        assign code = (g == 0) ? ctl_q.code0[SEL_W-1:0] : ctl_q.code1[SEL_W-1:0];
        assign hit  = (code != {SEL_W{1'b1}}) && evt_i[code];

        perfmon_counter #(.W(CNT_W)) u_ev (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (wr_ev[g]),
            .ld_val (wdata[CNT_W-1:0]),
            .clr    (rst_ev),
            .inc    (ctl_q.run && hit),
            .cnt    (ev_val[g]),
            .wrap   (wrap_v[g])
        );
    end

    // register read mux
    always_comb begin
        unique case (reg_ofs_e'(addr))
            OFS_CTRL: rdata = ctrl_img;
            OFS_CYC:  rdata = DATA_W'(cyc_val);
            OFS_EV0:  rdata = DATA_W'(ev_val[0]);
            OFS_EV1:  rdata = DATA_W'(ev_val[1]);
        endcase
    end

    logic unused_evt;
    assign unused_evt = (NUM_EVT == 0);
endmodule

// File: rtl/perfmon_unit_chk.sv
module perfmon_unit_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [31:0]      wdata,
    input logic [31:0]      rdata,
    input logic             irq,
    input logic             run,
    input logic [2:0]       flags,
    input logic [2:0]       ie,
    input logic [CNT_W-1:0] cyc_val,
    input logic [CNT_W-1:0] ev0_val,
    input logic [CNT_W-1:0] ev1_val
);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd0) |-> (rdata[31:28] == 4'd0 && !rdata[11] && !rdata[7] && rdata[2:1] == 2'd0));

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> ($stable(cyc_val) && $stable(ev0_val) && $stable(ev1_val)));

    // R6
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_en) |=> (cyc_val == $past(cyc_val) || cyc_val == $past(cyc_val) + CNT_W'(1)));

    // R7
    ev_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && wdata[1]) |=> (ev0_val == '0 && ev1_val == '0));

    // R8
    ev0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2) |=> (ev0_val == $past(wdata[CNT_W-1:0])));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 2'd0) |=> ((flags & $past(flags)) == $past(flags)));

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie != 3'd0 && flags != 3'd0));
endmodule

bind perfmon_unit perfmon_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .run     (ctl_q.run),
    .flags   (ctl_q.wf),
    .ie      (ctl_q.ie),
    .cyc_val (cyc_val),
    .ev0_val (ev_val[0]),
    .ev1_val (ev_val[1])
);

// File: tb/perfmon_unit_test.sv
`timescale 1ns/1ps
module perfmon_unit_test;
    localparam int PSC_LOG2 = 2;
    localparam int PSC_DIV  = 1 << PSC_LOG2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [255:0] evt = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    bit        m_run, m_psc;
    bit [2:0]  m_ie, m_wf;
    bit [7:0]  m_code0, m_code1;
    bit [31:0] m_cyc, m_ev0, m_ev1;
    int        m_phase;

    perfmon_unit #(.PSC_LOG2(PSC_LOG2)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .evt_i (evt),
        .irq   (irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] m_image();
        bit [31:0] v = '0;
        v[0]     = m_run;
        v[3]     = m_psc;
        v[6:4]   = m_ie;
        v[10:8]  = m_wf;
        v[19:12] = m_code0;
        v[27:20] = m_code1;
        return v;
    endfunction

    function automatic bit [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_image();
            2'd1: return m_cyc;
            2'd2: return m_ev0;
            default: return m_ev1;
        endcase
    endfunction

    // one clock: predict, advance, compare
    task automatic step();
        bit [2:0]  wr_flags = '0;
        bit        wctl = wr_en && addr == 2'd0;
        bit        tk   = m_run && (m_phase == PSC_DIV - 1);
        bit        c_inc = m_run && (!m_psc || tk);
        bit        e0 = m_run && m_code0 != 8'hFF && evt[m_code0];
        bit        e1 = m_run && m_code1 != 8'hFF && evt[m_code1];
        bit [31:0] n_cyc = m_cyc, n_e0 = m_ev0, n_e1 = m_ev1;
        int        n_phase = m_phase;
        string     tag;

        if (m_run) n_phase = (m_phase + 1) % PSC_DIV;
        if (wctl && wdata[2]) n_phase = 0;

        if (wr_en && addr == 2'd1) n_cyc = wdata;
        else if (wctl && wdata[2]) n_cyc = 0;
        else if (c_inc) begin
            if (m_cyc == 32'hFFFF_FFFF) wr_flags[2] = 1'b1;
            n_cyc = m_cyc + 1;
        end
        if (wr_en && addr == 2'd2) n_e0 = wdata;
        else if (wctl && wdata[1]) n_e0 = 0;
        else if (e0) begin
            if (m_ev0 == 32'hFFFF_FFFF) wr_flags[0] = 1'b1;
            n_e0 = m_ev0 + 1;
        end
        if (wr_en && addr == 2'd3) n_e1 = wdata;
        else if (wctl && wdata[1]) n_e1 = 0;
        else if (e1) begin
            if (m_ev1 == 32'hFFFF_FFFF) wr_flags[1] = 1'b1;
            n_e1 = m_ev1 + 1;
        end

        @(posedge clk);
        @(negedge clk);
        if (wctl) begin
            m_run   = wdata[0];
            m_psc   = wdata[3];
            m_ie    = wdata[6:4];
            m_code0 = wdata[19:12];
            m_code1 = wdata[27:20];
            m_wf    = m_wf & ~wdata[10:8];
        end
        m_wf    = m_wf | wr_flags;
        m_cyc   = n_cyc;
        m_ev0   = n_e0;
        m_ev1   = n_e1;
        m_phase = n_phase;

        case (addr)
            2'd0: tag = "R2 ctrl";
            2'd1: tag = "R6 cycle";
            default: tag = "R4 event";
        endcase
        chk(tag, rdata, m_read(addr));
        chk("R11 irq", {31'd0, irq}, {31'd0, |(m_wf & m_ie)});
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
        chk({tag, " model"}, rdata, m_read(a));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        m_run = 0; m_psc = 0; m_ie = 0; m_wf = 0;
        m_code0 = 8'hFF; m_code1 = 8'hFF;
        m_cyc = 0; m_ev0 = 0; m_ev1 = 0; m_phase = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1 ctrl", 2'd0, 32'h0FFF_F000);
        rd("R1 cyc", 2'd1, 32'd0);
        rd("R1 ev0", 2'd2, 32'd0);
        rd("R1 ev1", 2'd3, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R4 event counting: code0 = 0x07, code1 = 0x05
        wr(2'd0, 32'h0050_7001);
        evt[7] = 1'b1; idle(3);
        evt[7] = 1'b0; evt[5] = 1'b1; idle(1);
        evt[7] = 1'b1; idle(1);
        evt = '0; idle(2);
        rd("R4 ev0", 2'd2, 32'd4);
        rd("R4 ev1", 2'd3, 32'd2);

        // R5 code 0xFF ignores evt[255]
        wr(2'd0, 32'h005F_F001);
        evt[255] = 1'b1; idle(3);
        evt = '0;
        rd("R5 ev0", 2'd2, 32'd4);

        // R3 halted: nothing counts
        wr(2'd0, 32'h0050_7000);
        addr = 2'd1; #1; hold = rdata;
        evt[7] = 1'b1; evt[5] = 1'b1; idle(4);
        evt = '0;
        rd("R3 ev0", 2'd2, 32'd4);
        rd("R3 ev1", 2'd3, 32'd2);
        rd("R3 cyc", 2'd1, hold);

        // R6 prescaled cycle count, phase restarted by cycle reset
        wr(2'd0, 32'h0050_700D);
        rd("R7 cyc strobe", 2'd1, 32'd0);
        idle(8);
        rd("R6 prescaled", 2'd1, 32'd2);
        idle(3);
        rd("R6 prescaled phase", 2'd1, 32'd2);
        idle(1);
        rd("R6 prescaled tick", 2'd1, 32'd3);
        wr(2'd0, 32'h0050_7005);
        idle(10);
        rd("R6 every clock", 2'd1, 32'd10);

        // R8 load, R9 wrap, R11 irq, R10 clear
        wr(2'd2, 32'hFFFF_FFFE);
        rd("R8 load", 2'd2, 32'hFFFF_FFFE);
        wr(2'd0, 32'h0050_7011);
        evt[7] = 1'b1; idle(2);
        evt = '0;
        rd("R9 wrapped", 2'd2, 32'd0);
        rd("R9 flag", 2'd0, 32'h0050_7111);
        chk("R11 irq set", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h0050_7011);
        rd("R10 zero keeps", 2'd0, 32'h0050_7111);
        wr(2'd0, 32'h0050_7111);
        rd("R10 one clears", 2'd0, 32'h0050_7011);
        chk("R11 irq clear", {31'd0, irq}, 32'd0);

        // R8 load wins over counting
        evt[7] = 1'b1;
        wr(2'd2, 32'h0000_0100);
        rd("R8 load priority", 2'd2, 32'h0000_0100);
        // R7 event reset wins over counting
        wr(2'd0, 32'h0050_7013);
        rd("R7 ev clear", 2'd2, 32'd0);
        rd("R2 strobe not stored", 2'd0, 32'h0050_7011);
        idle(1);
        evt = '0;
        rd("R7 counts after", 2'd2, 32'd1);

        // R10 wrap and clear on one edge
        wr(2'd0, 32'h0050_7041);
        wr(2'd1, 32'hFFFF_FFFE);
        idle(1);
        wr(2'd0, 32'h0050_7441);
        rd("R10 set wins", 2'd0, 32'h0050_7441);
        chk("R11 cyc irq", {31'd0, irq}, 32'd1);

        // R11 flag set but enable off
        wr(2'd0, 32'h0050_7001);
        chk("R11 masked", {31'd0, irq}, 32'd0);

        // R2 reserved bits after all-ones write
        wr(2'd0, 32'hFFFF_FFFF);
        rd("R2 reserved", 2'd0, 32'h0FFF_F079);
        idle(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule